// File: doc/BRIEF.md
# Protected Toy CPU Sequencer

A multi-cycle fetch-decode-execute engine for a machine with no register file: every operand and result lives in one 256-byte memory that holds both code and data. An instruction is four bytes long: an operation byte, a first source cell address, a second source cell address and a destination cell address. The core steps through them over a byte-wide synchronous memory port. A read address presented in one cycle returns its data in the next cycle, and a write is taken at the clock edge.

A one-bit mode register separates system mode (0) from user mode (1). In user mode, every instruction fetch and every data access (source, pointer target, destination) is compared against a fixed reserved region, addresses 0 to OS_LIMIT-1. A violation, a privileged mode write, an unknown operation, a trap and a pending clock interrupt all redirect to fixed entry addresses. Each of these saves the current PC into a saved-PC register and forces system mode in the same cycle. A return instruction restores the PC from the saved copy and re-enters user mode. When the core takes the interrupt, it raises a one-cycle acknowledge that lets the external timer clear its request and start counting again.

Top module: `toycpu_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, the PC is 0, the mode is system (0), the saved PC is 0, the trap ID is 0, the fetch-boundary flag is high and no memory write is issued.
- R2: Instruction bytes are operation, source A, source B and destination, read from PC, PC+1, PC+2 and PC+3. Operation codes 1, 2, 3 and 4 write A+B, A-B, the low byte of A*B and A/B, all unsigned 8-bit, into the destination cell. The PC then advances by 4.
- R3: A divide (code 4) whose second source is 0 writes 0 to the destination.
- R4: When bit 7 of the operation byte is 1, source A is fetched indirectly. The cell named by the A byte holds the address of the cell that supplies the value. The low 7 bits give the operation.
- R5: Code 5 branches to the destination byte if source A is zero and otherwise advances the PC by 4. Code 6 jumps to the destination byte. Code 7 decrements the destination cell modulo 256 and advances the PC by 4.
- R6: In user mode, a fetch from a PC below OS_LIMIT (100) is not performed. The PC goes to 60, the saved PC takes the refused PC, and the mode becomes system.
- R7: In user mode, any source, pointer or destination address below OS_LIMIT vectors to 60, with the saved PC set to the instruction's address. No memory cell is written by that instruction.
- R8: Code 10 in system mode sets the mode to bit 0 of source A and advances the PC by 4. In user mode it vectors to 64, as does any undefined operation code in either mode, with the saved PC set to the instruction's address.
- R9: Code 8 latches its source A byte as the trap ID and vectors to 68 in system mode, with the saved PC set to the trap instruction's address.
- R10: A high interrupt input at a fetch boundary vectors to 72, saves the PC, enters system mode and raises the acknowledge output for that one cycle. This check comes before the user fetch check.
- R11: Code 9 loads the PC from the saved PC and sets user mode, both in the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address for read or write |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| irq_in | input | 1 | Clock interrupt request |
| irq_clr | output | 1 | One-cycle acknowledge that clears and restarts the timer |
| fetch_o | output | 1 | High at an instruction boundary |
| mode_o | output | 1 | Mode register: 0 system, 1 user |
| pc_o | output | 8 | Program counter |
| epc_o | output | 8 | Saved program counter |
| trap_id_o | output | 8 | Service ID of the last trap |

## Verification
The arithmetic sweep covers every operation against a grid of operands that includes 0, 255 and 128. This catches lost wrap-around, a multiply that keeps the wrong byte, and a divide by zero that writes anything other than 0. The user-mode cases fault on a direct source, on a pointer cell's contents, and on a destination. The bench confirms that the protected cell still holds its old value, so a core that checked only fetches, or checked after writing, would show a corrupted cell or the wrong entry address. The interrupt is raised during a jump into the reserved region. A core that ran the protection check before the interrupt check would land at 60 instead of 72 with the wrong saved PC. The trap-and-return pair shows whether the saved PC and mode are restored together.

// File: rtl/toycpu_pkg.sv
package toycpu_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int OPC_W  = 7;

    localparam logic [OPC_W-1:0] OP_ADD  = 7'd1;
    localparam logic [OPC_W-1:0] OP_SUB  = 7'd2;
    localparam logic [OPC_W-1:0] OP_MUL  = 7'd3;
    localparam logic [OPC_W-1:0] OP_DIV  = 7'd4;
    localparam logic [OPC_W-1:0] OP_BZ   = 7'd5;
    localparam logic [OPC_W-1:0] OP_JMP  = 7'd6;
    localparam logic [OPC_W-1:0] OP_DEC  = 7'd7;
    localparam logic [OPC_W-1:0] OP_TRAP = 7'd8;
    localparam logic [OPC_W-1:0] OP_RTE  = 7'd9;
    localparam logic [OPC_W-1:0] OP_SETM = 7'd10;

    localparam logic [ADDR_W-1:0] VEC_MEM  = 8'd60;
    localparam logic [ADDR_W-1:0] VEC_MODE = 8'd64;
    localparam logic [ADDR_W-1:0] VEC_TRAP = 8'd68;
    localparam logic [ADDR_W-1:0] VEC_IRQ  = 8'd72;

    localparam logic MODE_SYS = 1'b0;
    localparam logic MODE_USR = 1'b1;

    typedef enum logic [3:0] {
        ST_FETCH, ST_OPC, ST_SRCA, ST_SRCB, ST_DEST,
        ST_DECODE, ST_LDA, ST_LDB, ST_LDD
    } state_t;

    typedef struct packed {
        logic              ind;
        logic [OPC_W-1:0]  op;
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] b;
        logic [ADDR_W-1:0] d;
    } instr_t;

    function automatic logic is_arith(input logic [OPC_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/toycpu_alu.sv
module toycpu_alu
    import toycpu_pkg::*;
(
    input  logic [OPC_W-1:0]  op,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        case (op)
            OP_ADD:  res = x + y;
            OP_SUB:  res = x - y;
            OP_MUL:  res = x * y;
            OP_DIV:  res = (y == '0) ? '0 : x / y;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/toycpu_guard.sv
module toycpu_guard
    import toycpu_pkg::*;
#(
    parameter int LIMIT = 100
)(
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              bad
);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LIMIT);
    assign bad = (mode == MODE_USR) && (addr < LIMIT_A);
endmodule

// File: rtl/toycpu_seq.sv
module toycpu_seq
    import toycpu_pkg::*;
#(
    parameter int OS_LIMIT = 100
)(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              irq_in,
    output logic              irq_clr,
    output logic              fetch_o,
    output logic              mode_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] epc_o,
    output logic [DATA_W-1:0] trap_id_o
);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(OS_LIMIT);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] THR  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    state_t            state_q, state_d;
    instr_t            ins_q, ins_d;
    logic [ADDR_W-1:0] pc_q, pc_d, epc_q, epc_d;
    logic [DATA_W-1:0] va_q, va_d, tid_q, tid_d;
    logic              mode_q, mode_d, ind_q, ind_d;
    logic [ADDR_W-1:0] chk_addr, vec_addr;
    logic              chk_bad, vec_take;
    logic [DATA_W-1:0] alu_res;

    toycpu_guard #(.LIMIT(OS_LIMIT)) u_guard (
        .mode(mode_q), .addr(chk_addr), .bad(chk_bad)
    );

    toycpu_alu u_alu (
        .op(ins_q.op), .x(va_q), .y(mem_rdata), .res(alu_res)
    );

    // Address that the current step would touch, for the protection check
    always_comb begin
        case (state_q)
            ST_DECODE: chk_addr = (ins_q.op == OP_DEC) ? ins_q.d : ins_q.a;
            ST_LDA:    chk_addr = ind_q ? mem_rdata : ins_q.b;
            ST_LDB:    chk_addr = ins_q.d;
            default:   chk_addr = pc_q;
        endcase
    end

    always_comb begin
        state_d   = state_q;
        ins_d     = ins_q;
        pc_d      = pc_q;
        epc_d     = epc_q;
        mode_d    = mode_q;
        va_d      = va_q;
        ind_d     = ind_q;
        tid_d     = tid_q;
        mem_addr  = chk_addr;
        mem_we    = 1'b0;
        mem_wdata = alu_res;
        irq_clr   = 1'b0;
        vec_take  = 1'b0;
        vec_addr  = VEC_MEM;
        case (state_q)
            ST_FETCH: begin
                if (irq_in) begin
                    vec_take = 1'b1;
                    vec_addr = VEC_IRQ;
                    irq_clr  = 1'b1;
                end else if (chk_bad) begin
                    vec_take = 1'b1;
                end else begin
                    state_d = ST_OPC;
                end
            end
            ST_OPC: begin
                ins_d.ind = mem_rdata[DATA_W-1];
                ins_d.op  = mem_rdata[OPC_W-1:0];
                mem_addr  = pc_q + ONE;
                state_d   = ST_SRCA;
            end
            ST_SRCA: begin
                ins_d.a  = mem_rdata;
                mem_addr = pc_q + TWO;
                state_d  = ST_SRCB;
            end
            ST_SRCB: begin
                ins_d.b  = mem_rdata;
                mem_addr = pc_q + THR;
                state_d  = ST_DEST;
            end
            ST_DEST: begin
                ins_d.d = mem_rdata;
                state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (is_arith(ins_q.op) || ins_q.op == OP_BZ || ins_q.op == OP_SETM) begin
                    if (ins_q.op == OP_SETM && mode_q == MODE_USR) begin
                        vec_take = 1'b1;
                        vec_addr = VEC_MODE;
                    end else if (chk_bad) begin
                        vec_take = 1'b1;
                    end else begin
                        ind_d   = ins_q.ind;
                        state_d = ST_LDA;
                    end
                end else if (ins_q.op == OP_JMP) begin
                    pc_d    = ins_q.d;
                    state_d = ST_FETCH;
                end else if (ins_q.op == OP_DEC) begin
                    if (chk_bad) vec_take = 1'b1;
                    else         state_d  = ST_LDD;
                end else if (ins_q.op == OP_TRAP) begin
                    tid_d    = ins_q.a;
                    vec_take = 1'b1;
                    vec_addr = VEC_TRAP;
                end else if (ins_q.op == OP_RTE) begin
                    pc_d    = epc_q;
                    mode_d  = MODE_USR;
                    state_d = ST_FETCH;
                end else begin
                    vec_take = 1'b1;
                    vec_addr = VEC_MODE;
                end
            end
            ST_LDA: begin
                if (ind_q) begin
                    if (chk_bad) vec_take = 1'b1;
                    else         ind_d    = 1'b0;
                end else if (ins_q.op == OP_BZ) begin
                    pc_d    = (mem_rdata == '0) ? ins_q.d : pc_q + STEP;
                    state_d = ST_FETCH;
                end else if (ins_q.op == OP_SETM) begin
                    mode_d  = mem_rdata[0];
                    pc_d    = pc_q + STEP;
                    state_d = ST_FETCH;
                end else if (chk_bad) begin
                    vec_take = 1'b1;
                end else begin
                    va_d    = mem_rdata;
                    state_d = ST_LDB;
                end
            end
            ST_LDB: begin
                if (chk_bad) begin
                    vec_take = 1'b1;
                end else begin
                    mem_we  = 1'b1;
                    pc_d    = pc_q + STEP;
                    state_d = ST_FETCH;
                end
            end
            ST_LDD: begin
                mem_addr  = ins_q.d;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata - DATA_W'(1);
                pc_d      = pc_q + STEP;
                state_d   = ST_FETCH;
            end
            default: state_d = ST_FETCH;
        endcase
        if (vec_take) begin
            epc_d   = pc_q;
            pc_d    = vec_addr;
            mode_d  = MODE_SYS;
            state_d = ST_FETCH;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            ins_q   <= '0;
            pc_q    <= '0;
            epc_q   <= '0;
            mode_q  <= MODE_SYS;
            va_q    <= '0;
            ind_q   <= 1'b0;
            tid_q   <= '0;
        end else begin
            state_q <= state_d;
            ins_q   <= ins_d;
            pc_q    <= pc_d;
            epc_q   <= epc_d;
            mode_q  <= mode_d;
            va_q    <= va_d;
            ind_q   <= ind_d;
            tid_q   <= tid_d;
        end
    end

    assign fetch_o   = (state_q == ST_FETCH);
    assign mode_o    = mode_q;
    assign pc_o      = pc_q;
    assign epc_o     = epc_q;
    assign trap_id_o = tid_q;

    AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mode_q == MODE_USR) |-> (mem_addr >= LIMIT_A)); // R7

    AST_VEC_ENTRY: assert property (@(posedge clk) disable iff (rst)
        vec_take |=> (mode_q == MODE_SYS && epc_q == $past(pc_q))); // R6

    AST_USER_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && !irq_in && mode_q == MODE_USR && pc_q < LIMIT_A)
        |=> (pc_q == VEC_MEM)); // R6

    AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && irq_in) |=> (pc_q == VEC_IRQ && mode_q == MODE_SYS)); // R10

    AST_RTE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && ins_q.op == OP_RTE)
        |=> (mode_q == MODE_USR && pc_q == $past(epc_q))); // R11
endmodule

// File: tb/toycpu_seq_bench.sv
module toycpu_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we, irq_clr, fetch_o, mode_o;
    logic [7:0] pc_o, epc_o, trap_id_o;
    logic       irq = 1'b0;
    logic       irq_arm = 1'b0;
    int         clr_cnt = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] mem [256];

    always #10 clk = ~clk;

    toycpu_seq u_toycpu_seq (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq_in(irq), .irq_clr(irq_clr),
        .fetch_o(fetch_o), .mode_o(mode_o), .pc_o(pc_o), .epc_o(epc_o), .trap_id_o(trap_id_o)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (irq_clr) irq <= 1'b0;
        else if (irq_arm) irq <= 1'b1;
        if (irq_clr) clr_cnt <= clr_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start();
        rst = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (2) @(posedge clk);
    endtask

    task automatic go();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put(input int at, input int op, input int a, input int b, input int d);
        mem[at] = 8'(op); mem[at+1] = 8'(a); mem[at+2] = 8'(b); mem[at+3] = 8'(d);
    endtask

    task automatic wait_pc(input int tgt, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (fetch_o && pc_o == 8'(tgt)) begin ok = 1'b1; break; end
        end
    endtask

    task automatic next_boundary(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!fetch_o) break;
        end
        for (int i = 0; i < 400; i++) begin
            if (fetch_o) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic enter_user(output bit ok);
        put(0, 6, 0, 0, 120);
        put(120, 10, 200, 0, 0);
        mem[200] = 8'd1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ok;
        int vals [8] = '{0, 1, 2, 7, 100, 128, 200, 255};
        int expv;

        // R1 reset state
        start();
        @(negedge clk);
        check("R1 pc", pc_o, 0);
        check("R1 mode", mode_o, 0);
        check("R1 epc", epc_o, 0);
        check("R1 trap id", trap_id_o, 0);
        check("R1 fetch", fetch_o, 1);
        check("R1 we", mem_we, 0);
        go();
        check("R1 pc after release", pc_o, 0);

        // R2 / R3 arithmetic sweep
        for (int op = 1; op <= 4; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    start();
                    put(0, op, 10, 11, 12);
                    mem[10] = 8'(vals[i]); mem[11] = 8'(vals[j]); mem[12] = 8'h5C;
                    go();
                    wait_pc(4, ok);
                    case (op)
                        1: expv = (vals[i] + vals[j]) & 255;
                        2: expv = (vals[i] - vals[j]) & 255;
                        3: expv = (vals[i] * vals[j]) & 255;
                        default: expv = (vals[j] == 0) ? 0 : vals[i] / vals[j];
                    endcase
                    check((op == 4 && vals[j] == 0) ? "R3 div zero" : "R2 arith",
                          ok ? int'(mem[12]) : 999, expv);
                end
            end
        end

        // R4 indirect source in system mode
        for (int i = 0; i < 8; i++) begin
            start();
            put(0, 8'h82, 10, 11, 12);
            mem[10] = 8'd50; mem[50] = 8'(vals[i]); mem[11] = 8'd3;
            go();
            wait_pc(4, ok);
            check("R4 indirect sub", ok ? int'(mem[12]) : 999, (vals[i] - 3) & 255);
        end

        // R5 BZ taken / not taken, JUMP, DEC wrap
        start(); put(0, 5, 10, 0, 80); mem[10] = 0; go();
        wait_pc(80, ok); check("R5 bz taken", ok, 1);
        start(); put(0, 5, 10, 0, 80); mem[10] = 3; go();
        wait_pc(4, ok); check("R5 bz not taken", ok, 1);
        start(); put(0, 6, 0, 0, 88); go();
        wait_pc(88, ok); check("R5 jump", ok, 1);
        start(); put(0, 7, 0, 0, 12); mem[12] = 0; go();
        wait_pc(4, ok); check("R5 dec wrap", ok ? int'(mem[12]) : 999, 255);
        start(); put(0, 7, 0, 0, 12); mem[12] = 5; go();
        wait_pc(4, ok); check("R5 dec", ok ? int'(mem[12]) : 999, 4);

        // R8 system SETMODE enters user mode
        start(); enter_user(ok); put(124, 6, 0, 0, 124); go();
        wait_pc(124, ok); check("R8 setmode system", ok ? int'(mode_o) : 9, 1);

        // R6 user fetch below limit
        start(); enter_user(ok); put(124, 6, 0, 0, 40); go();
        wait_pc(60, ok);
        check("R6 fetch vector", ok, 1);
        check("R6 epc", epc_o, 40);
        check("R6 mode", mode_o, 0);

        // R7 direct source fault, no write
        start(); enter_user(ok); put(124, 1, 5, 210, 220); mem[220] = 8'h33; go();
        wait_pc(60, ok);
        check("R7 src vector", ok ? int'(epc_o) : 999, 124);
        check("R7 src no write", mem[220], 8'h33);

        // R7 destination fault, no write
        start(); enter_user(ok); put(124, 1, 210, 211, 30); mem[30] = 8'h44; go();
        wait_pc(60, ok);
        check("R7 dst vector", ok ? int'(epc_o) : 999, 124);
        check("R7 dst no write", mem[30], 8'h44);

        // R7 pointer fault
        start(); enter_user(ok); put(124, 8'h81, 201, 210, 220); mem[201] = 7; mem[220] = 8'h11; go();
        wait_pc(60, ok);
        check("R7 ptr vector", ok ? int'(epc_o) : 999, 124);
        check("R7 ptr no write", mem[220], 8'h11);

        // R4 legal indirect in user mode
        start(); enter_user(ok); put(124, 8'h81, 202, 210, 220);
        mem[202] = 230; mem[230] = 9; mem[210] = 5; go();
        wait_pc(128, ok);
        check("R4 user indirect", ok ? int'(mem[220]) : 999, 14);

        // R8 user SETMODE and undefined opcode
        start(); enter_user(ok); put(124, 10, 200, 0, 0); go();
        wait_pc(64, ok);
        check("R8 user setmode", ok ? int'(epc_o) : 999, 124);
        check("R8 user setmode mode", mode_o, 0);
        start(); put(0, 11, 0, 0, 0); go();
        wait_pc(64, ok);
        check("R8 undefined op", ok ? int'(epc_o) : 999, 0);

        // R9 trap, then R11 return
        start(); enter_user(ok); put(124, 8, 8'h5A, 0, 0); put(68, 9, 0, 0, 0); go();
        wait_pc(68, ok);
        check("R9 trap vector", ok, 1);
        check("R9 trap id", trap_id_o, 8'h5A);
        check("R9 epc", epc_o, 124);
        check("R9 mode", mode_o, 0);
        next_boundary(ok);
        check("R11 rte pc", ok ? int'(pc_o) : 999, 124);
        check("R11 rte mode", mode_o, 1);

        // R10 interrupt during user loop
        start(); enter_user(ok); put(124, 6, 0, 0, 124); go();
        wait_pc(124, ok);
        begin
            int c0 = clr_cnt;
            irq_arm = 1'b1; @(negedge clk); irq_arm = 1'b0;
            wait_pc(72, ok);
            @(negedge clk);
            check("R10 irq vector", ok, 1);
            check("R10 irq epc", epc_o, 124);
            check("R10 irq ack pulses", clr_cnt - c0, 1);
        end

        // R10 interrupt wins over user fetch fault
        start(); enter_user(ok); put(124, 6, 0, 0, 40); go();
        wait_pc(124, ok);
        @(negedge clk);
        irq_arm = 1'b1; @(negedge clk); irq_arm = 1'b0;
        wait_pc(72, ok);
        check("R10 priority vector", ok, 1);
        check("R10 priority epc", epc_o, 40);
        check("R10 priority mode", mode_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule